// File: doc/BRIEF.md
# Phase-Angle Trigger Pulse Controller

This block fires one gate pulse per mains half-cycle, at a phase angle that software sets as a delay word. The zero-crossing input and the half-cycle polarity input come from an outside detector. Both pass through a two-flop synchronizer. The rising edge of the synchronized zero-crossing signal gives a single-cycle restart strobe. A saturating ramp counter advances on a prescaled tick and starts again from zero at each strobe. When the ramp equals the delay word, a trigger memory is set. That memory fires a one-shot whose length, in clock cycles, comes from a width word.

The one-shot drives one of two registered outputs. Which one is chosen by the polarity captured at the last crossing. A clear at a crossing, or an active inhibit, always wins over a set. Inhibit also ends a pulse that is already running. A pulse still running when the next crossing arrives is cut off, so it never spills onto the other output. A ramp of N bits with prescale P covers a half-cycle of about P·(2^N−1) clock cycles, which spans the full 0 to 180 degree range.

Top module: `phase_trig_ctrl`

## Requirements
- R1: A crossing is a rising edge on `zc_in`. Let edge k be the first clock edge that samples `zc_in` high. With delay word d and prescale P (default 4), the selected output first goes high after edge k+4+d·P.
- R2: While `rst` is high, and after it is released, both outputs are 0 until a crossing has been seen and a trigger has fired.
- R3: A pulse stays high for exactly `width_word` clock cycles. A width word of 0 gives no pulse.
- R4: If `pol_in` is 1 at the crossing, only `out_a` pulses in that half-cycle. If it is 0, only `out_b` pulses. The two outputs are never high together.
- R5: At most one pulse occurs per half-cycle. A change to the delay word after the trigger has fired, even to a value the ramp has not yet reached, starts no further pulse.
- R6: An `inhibit` level sampled at a clock edge clears the trigger memory and drives both outputs to 0 after that edge. Once the trigger has fired, releasing inhibit later in the same half-cycle does not bring back a pulse.
- R7: A clear always beats a set. If `inhibit` is high across the cycle in which the ramp equals the delay word, no pulse occurs in that half-cycle. A crossing strobe in the same cycle as a match also leaves the memory clear.
- R8: The ramp holds at its all-ones value and does not wrap. A delay word of all ones never fires.
- R9: A pulse still running at a new crossing ends. Both outputs are 0 after edge k+2 of that crossing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| zc_in | input | 1 | Raw zero-crossing level; its rising edge marks a crossing |
| pol_in | input | 1 | Raw half-cycle polarity, 1 = positive |
| inhibit | input | 1 | Synchronous inhibit; clears the trigger memory and blocks the outputs |
| delay_word | input | RAMP_W (8) | Phase delay in ramp steps |
| width_word | input | PW_W (8) | Pulse width in clock cycles |
| out_a | output | 1 | Trigger pulse for the positive half-cycle |
| out_b | output | 1 | Trigger pulse for the negative half-cycle |

## Verification
A table sweeps the delay word across zero, small values, mid values, the last value that still fires, and the saturated all-ones value. It also alternates polarity and varies the width. In this way one sweep separates errors in the ramp rate or latency offset, wrong channel steering, pulse-length errors and a ramp that wraps around. Directed cases then probe the ordering rules. Inhibit is raised in the middle of a pulse and then released. Inhibit is held across the match point. The delay word is moved ahead of the ramp after a trigger has fired. A new crossing arrives during a long pulse. Each of these cases shows whether a clear really beats a set and whether a second pulse can slip through.

// File: rtl/ptc_pkg.sv
package ptc_pkg;
  typedef enum logic {
    HALF_NEG = 1'b0,
    HALF_POS = 1'b1
  } half_t;
endpackage

// File: rtl/ptc_sync_edge.sv
module ptc_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic zc_raw,
  input  logic pol_raw,
  output logic zc_stb,
  output logic pol_sync
);
  logic [STAGES:0]   zc_sh;
  logic [STAGES-1:0] pol_sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      zc_sh  <= '0;
      pol_sh <= '0;
    end else begin
      zc_sh  <= {zc_sh[STAGES-1:0], zc_raw};
      pol_sh <= {pol_sh[STAGES-2:0], pol_raw};
    end
  end

  // one-cycle strobe on the synchronized rising edge
  assign zc_stb   = zc_sh[STAGES-1] & ~zc_sh[STAGES];
  assign pol_sync = pol_sh[STAGES-1];
endmodule

// File: rtl/ptc_ramp.sv
module ptc_ramp #(
  parameter int RAMP_W    = 8,
  parameter int PRESC_DIV = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              restart,
  output logic [RAMP_W-1:0] ramp,
  output logic              at_max
);
  localparam int PRESC_W = (PRESC_DIV > 1) ? $clog2(PRESC_DIV) : 1;
  localparam logic [PRESC_W-1:0] PRESC_LAST = PRESC_W'(PRESC_DIV - 1);
  localparam logic [RAMP_W-1:0]  RAMP_MAX   = '1;

  logic [PRESC_W-1:0] pre;

  assign at_max = (ramp == RAMP_MAX);

  always_ff @(posedge clk) begin
    if (rst) begin
      pre  <= '0;
      ramp <= RAMP_MAX;           // parked: nothing fires before a crossing
    end else if (restart) begin
      pre  <= '0;
      ramp <= '0;
    end else if (pre == PRESC_LAST) begin
      pre <= '0;
      if (!at_max) ramp <= ramp + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end
endmodule

// File: rtl/ptc_oneshot.sv
module ptc_oneshot #(
  parameter int PW_W = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            clear,
  input  logic            start,
  input  logic [PW_W-1:0] width,
  output logic            active
);
  logic [PW_W-1:0] remain;

  always_ff @(posedge clk) begin
    if (rst || clear)         remain <= '0;
    else if (start)           remain <= width;
    else if (remain != '0)    remain <= remain - 1'b1;
  end

  assign active = (remain != '0);
endmodule

// File: rtl/phase_trig_ctrl.sv
module phase_trig_ctrl #(
  parameter int RAMP_W      = 8,
  parameter int PRESC_DIV   = 4,
  parameter int PW_W        = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              zc_in,
  input  logic              pol_in,
  input  logic              inhibit,
  input  logic [RAMP_W-1:0] delay_word,
  input  logic [PW_W-1:0]   width_word,
  output logic              out_a,
  output logic              out_b
);
  import ptc_pkg::*;

  logic              zc_stb;
  logic              pol_sync;
  logic [RAMP_W-1:0] ramp;
  logic              ramp_max;
  logic              trig_latch;
  logic              armed;
  logic              pulse_on;
  logic              hit;
  logic              set_evt;
  logic              clr_evt;
  half_t             half_q;

  ptc_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .zc_raw(zc_in), .pol_raw(pol_in),
    .zc_stb(zc_stb), .pol_sync(pol_sync)
  );

  ptc_ramp #(.RAMP_W(RAMP_W), .PRESC_DIV(PRESC_DIV)) u_ramp (
    .clk(clk), .rst(rst), .restart(zc_stb), .ramp(ramp), .at_max(ramp_max)
  );

  // compare is masked once the ramp is parked at its ceiling
  assign hit     = (ramp == delay_word) && !ramp_max;
  assign clr_evt = zc_stb || inhibit;
  assign set_evt = hit && armed && !trig_latch && !clr_evt;

  always_ff @(posedge clk) begin
    if (rst) begin
      trig_latch <= 1'b0;
      armed      <= 1'b0;
      half_q     <= HALF_NEG;
    end else begin
      if (clr_evt)      trig_latch <= 1'b0;
      else if (set_evt) trig_latch <= 1'b1;

      if (zc_stb) begin
        armed  <= 1'b1;
        half_q <= half_t'(pol_sync);
      end else if (set_evt) begin
        armed <= 1'b0;
      end
    end
  end

  ptc_oneshot #(.PW_W(PW_W)) u_shot (
    .clk(clk), .rst(rst), .clear(clr_evt), .start(set_evt),
    .width(width_word), .active(pulse_on)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_a <= 1'b0;
      out_b <= 1'b0;
    end else begin
      out_a <= pulse_on && !clr_evt && (half_q == HALF_POS);
      out_b <= pulse_on && !clr_evt && (half_q == HALF_NEG);
    end
  end
endmodule

// File: rtl/ptc_checker.sv
module ptc_checker #(
  parameter int RAMP_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              zc_stb,
  input logic              inhibit,
  input logic              trig_latch,
  input logic [RAMP_W-1:0] ramp,
  input logic [RAMP_W-1:0] delay_word,
  input logic              out_a,
  input logic              out_b
);
  localparam logic [RAMP_W-1:0] RMAX = '1;

  logic       latch_d;
  logic [1:0] sets_in_half;

  always_ff @(posedge clk) begin
    if (rst) begin
      latch_d      <= 1'b0;
      sets_in_half <= '0;
    end else begin
      latch_d <= trig_latch;
      if (zc_stb)                                     sets_in_half <= '0;
      else if (trig_latch && !latch_d && sets_in_half != 2'd3) sets_in_half <= sets_in_half + 1'b1;
    end
  end

  p_reset_quiet_r2: assert property (@(posedge clk) rst |=> (!out_a && !out_b));

  p_excl_outputs_r4: assert property (@(posedge clk) disable iff (rst)
    !(out_a && out_b));

  p_one_set_r5: assert property (@(posedge clk) disable iff (rst)
    sets_in_half <= 2'd1);

  p_set_on_match_r1: assert property (@(posedge clk) disable iff (rst)
    (trig_latch && !latch_d) |-> ($past(ramp) == $past(delay_word)));

  p_inhibit_cuts_r6: assert property (@(posedge clk) disable iff (rst)
    inhibit |=> (!out_a && !out_b));

  p_clear_wins_r7: assert property (@(posedge clk) disable iff (rst)
    (zc_stb || inhibit) |=> !trig_latch);

  p_ramp_holds_r8: assert property (@(posedge clk) disable iff (rst)
    (ramp == RMAX && !zc_stb) |=> (ramp == RMAX));

  p_zc_truncates_r9: assert property (@(posedge clk) disable iff (rst)
    zc_stb |=> (!out_a && !out_b));
endmodule

bind phase_trig_ctrl ptc_checker #(.RAMP_W(RAMP_W)) u_chk (
  .clk(clk), .rst(rst), .zc_stb(zc_stb), .inhibit(inhibit),
  .trig_latch(trig_latch), .ramp(ramp), .delay_word(delay_word),
  .out_a(out_a), .out_b(out_b)
);

// File: tb/phase_trig_ctrl_bench.sv
`timescale 1ns/1ps
module phase_trig_ctrl_bench;
  localparam int P = 4;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       zc_in = 1'b0;
  logic       pol_in = 1'b0;
  logic       inhibit = 1'b0;
  logic [7:0] delay_word = 8'd0;
  logic [7:0] width_word = 8'd0;
  logic       out_a;
  logic       out_b;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #4 clk = ~clk;

  phase_trig_ctrl u_phase_trig_ctrl (
    .clk(clk), .rst(rst), .zc_in(zc_in), .pol_in(pol_in), .inhibit(inhibit),
    .delay_word(delay_word), .width_word(width_word), .out_a(out_a), .out_b(out_b)
  );

  // {pol, width, delay}
  localparam logic [16:0] VEC [9] = '{
    {1'b1, 8'd3,  8'd0},
    {1'b0, 8'd5,  8'd1},
    {1'b1, 8'd1,  8'd5},
    {1'b0, 8'd8,  8'd20},
    {1'b1, 8'd16, 8'd37},
    {1'b0, 8'd2,  8'd100},
    {1'b1, 8'd4,  8'd254},
    {1'b0, 8'd4,  8'd255},
    {1'b1, 8'd0,  8'd10}
  };

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // raises a crossing; returns after two negedges (samples i=1,2 skipped)
  task automatic start_zc(input logic [7:0] d, input logic [7:0] w, input logic pos);
    @(negedge clk);
    delay_word = d; width_word = w; pol_in = pos; zc_in = 1'b1;
    @(negedge clk);
    @(negedge clk);
    zc_in = 1'b0;
  endtask

  task automatic observe(input int n, output int na, output int nb,
                         output int fa, output int fb);
    na = 0; nb = 0; fa = 0; fb = 0;
    for (int j = 1; j <= n; j++) begin
      @(negedge clk);
      if (out_a) begin na++; if (fa == 0) fa = j; end
      if (out_b) begin nb++; if (fb == 0) fb = j; end
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    int na, nb, fa, fb;
    repeat (4) @(negedge clk);
    chk("R2 out_a in reset", out_a, 0);
    chk("R2 out_b in reset", out_b, 0);
    rst = 1'b0;
    observe(20, na, nb, fa, fb);
    chk("R2 no pulse before crossing", na + nb, 0);

    // table sweep: rise expected at observe index 3+d*P (R1)
    for (int v = 0; v < 9; v++) begin
      logic [7:0] d, w;
      logic pos;
      bit fire;
      d = VEC[v][7:0]; w = VEC[v][15:8]; pos = VEC[v][16];
      fire = (d != 8'hFF) && (w != 8'd0);
      start_zc(d, w, pos);
      observe(3 + int'(d) * P + int'(w) + 8, na, nb, fa, fb);
      if (fire) begin
        chk("R1 trigger delay", pos ? fa : fb, 3 + int'(d) * P);
        chk("R3 pulse width", pos ? na : nb, int'(w));
      end else begin
        chk((d == 8'hFF) ? "R8 saturated delay fires" : "R3 zero width fires",
            pos ? na : nb, 0);
      end
      chk("R4 opposite output", pos ? nb : na, 0);
    end

    // R6: inhibit mid-pulse, then release, no re-trigger
    start_zc(8'd3, 8'd20, 1'b1);
    observe(19, na, nb, fa, fb);
    chk("R6 pulse running before inhibit", out_a, 1);
    inhibit = 1'b1;
    @(negedge clk);
    chk("R6 inhibit cuts pulse", out_a, 0);
    inhibit = 1'b0;
    observe(200, na, nb, fa, fb);
    chk("R6 no pulse after release", na + nb, 0);

    // R7: inhibit held across the match point
    inhibit = 1'b1;
    start_zc(8'd4, 8'd5, 1'b0);
    observe(30, na, nb, fa, fb);
    chk("R7 set loses to inhibit", na + nb, 0);
    inhibit = 1'b0;
    observe(100, na, nb, fa, fb);
    chk("R7 no late pulse", na + nb, 0);

    // R5: delay moved ahead of the ramp after trigger
    start_zc(8'd6, 8'd3, 1'b1);
    observe(40, na, nb, fa, fb);
    chk("R5 first pulse width", na, 3);
    delay_word = 8'd60;
    observe(400, na, nb, fa, fb);
    chk("R5 no second pulse at 60", na + nb, 0);
    delay_word = 8'd200;
    observe(500, na, nb, fa, fb);
    chk("R5 no second pulse at 200", na + nb, 0);

    // R9: crossing during a long pulse
    start_zc(8'd2, 8'd200, 1'b1);
    observe(20, na, nb, fa, fb);
    chk("R9 long pulse running", out_a, 1);
    start_zc(8'd255, 8'd4, 1'b0);
    observe(1, na, nb, fa, fb);
    chk("R9 out_a cut at crossing", na, 0);
    observe(100, na, nb, fa, fb);
    chk("R9 no spill onto out_b", na + nb, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule